// File: doc/BRIEF.md
# RS-485 Multi-Drop Receive Gate

This block sits between a UART character receiver that produces 9-bit characters and the receive FIFO. The ninth bit tells the two kinds of character apart. When it is 1 the character is an address. When it is 0 the character is data. The block decides which characters reach the FIFO. In the addressed-filter mode it compares each address against a programmed station address. In the software-gated mode a receiver-off control decides whether data is accepted. With no mode selected, every character is passed through.

The block also raises a sticky address-seen flag, which is cleared by writing one. It drives the transceiver direction (RTS) pin. That pin follows either a manual request or, in automatic direction mode, the activity of the transmitter. A polarity control selects whether the pin is active low or active high.

All results are registered. Each one is due one clock after the input that causes it, except for the pin polarity, which applies to the registered state without delay.

Top module: `rs485_rx_gate`

## Requirements
- R1: With neither addressing mode enabled, every valid character produces exactly one `fifo_we_o` pulse one cycle later, with `fifo_data_o` equal to bits [7:0] of the character. With no `char_valid_i`, `fifo_we_o` stays 0.
- R2: A valid character whose bit 8 is 1 sets `addr_det_o` on the next cycle when `addr_det_en_i` is 1. It leaves the flag unchanged when `addr_det_en_i` is 0. A data character (bit 8 = 0) never sets the flag.
- R3: A one-cycle pulse on `addr_clr_i` clears `addr_det_o` on the next cycle. If a set condition occurs in the same cycle as the clear, the set wins.
- R4: In auto-address mode (`auto_addr_en_i`=1, `multidrop_en_i`=0), data characters are discarded until an address equal to `match_addr_i` arrives. Address characters, matching or not, are never written to the FIFO.
- R5: In auto-address mode, once a matching address has been seen, data characters are written until a non-matching address arrives. Turning auto-address mode off forgets the match.
- R6: When `multidrop_en_i` and `auto_addr_en_i` are both 1 (an illegal setting), no character is written.
- R7: In multi-drop mode (`multidrop_en_i`=1, `auto_addr_en_i`=0), an address character is always written, even while `rx_off_i` is 1.
- R8: In multi-drop mode, a data character is written only while `rx_off_i` is 0.
- R9: With `auto_dir_en_i`=1, the internal RTS-active state equals `tx_busy_i` one cycle later, and `rts_req_i` has no effect.
- R10: With `auto_dir_en_i`=0, the RTS-active state equals `rts_req_i` one cycle later. After reset the state is inactive.
- R11: `rts_o` is the inverse of the active state when `rts_low_act_i`=1 and equals it when `rts_low_act_i`=0. A change of polarity shows on the pin in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_valid_i | input | 1 | Received character strobe |
| char_data_i | input | 9 | Received character; bit 8 = address marker |
| multidrop_en_i | input | 1 | Software-gated multi-drop mode |
| auto_addr_en_i | input | 1 | Hardware address-match mode |
| auto_dir_en_i | input | 1 | RTS driven from transmitter activity |
| addr_det_en_i | input | 1 | Enable for the address-seen flag |
| match_addr_i | input | 8 | Station address for auto-address mode |
| rx_off_i | input | 1 | Rejects data characters in multi-drop mode |
| tx_busy_i | input | 1 | Transmitter busy from first start bit to last stop bit |
| rts_req_i | input | 1 | Manual RTS request (1 = active) |
| rts_low_act_i | input | 1 | 1 = RTS pin active low, 0 = active high |
| addr_clr_i | input | 1 | Write-one-to-clear pulse for the address flag |
| fifo_we_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 8 | FIFO write data |
| addr_det_o | output | 1 | Sticky address-seen flag |
| rts_o | output | 1 | RTS / direction pin |

## Verification
FIFO writes, the address flag and the RTS-active state are all due on the first clock edge after the stimulus. The bench applies every input on a falling edge and samples on the next falling edge, so each check falls half a cycle after the register that produces its result. The polarity input reaches the pin through logic only, so the bench checks it a short delay after changing it, before any clock edge. Filtering state is checked through the FIFO strobe on later data characters.

// File: rtl/rs485_pkg.sv
package rs485_pkg;
  typedef enum logic [1:0] {
    MODE_PASS      = 2'd0,
    MODE_MULTIDROP = 2'd1,
    MODE_AUTO_ADDR = 2'd2,
    MODE_CONFLICT  = 2'd3
  } rx_mode_e;

  function automatic rx_mode_e decode_mode(input logic md, input logic aad);
    case ({aad, md})
      2'b00:   return MODE_PASS;
      2'b01:   return MODE_MULTIDROP;
      2'b10:   return MODE_AUTO_ADDR;
      default: return MODE_CONFLICT;
    endcase
  endfunction
endpackage

// File: rtl/rs485_addr_filter.sv
module rs485_addr_filter
  import rs485_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W:0]   char_i,
  input  rx_mode_e          mode_i,
  input  logic [DATA_W-1:0] match_i,
  input  logic              rx_off_i,
  output logic              we_o,
  output logic [DATA_W-1:0] data_o
);
  logic              is_addr, hit, accept, matched_q;
  logic [DATA_W-1:0] payload;

  assign is_addr = char_i[DATA_W];
  assign payload = char_i[DATA_W-1:0];
  assign hit     = (payload == match_i);

  always_comb begin
    unique case (mode_i)
      MODE_PASS:      accept = 1'b1;
      MODE_MULTIDROP: accept = is_addr | ~rx_off_i;
      MODE_AUTO_ADDR: accept = ~is_addr & matched_q;
      default:        accept = 1'b0;
    endcase
  end

  // match state lives only while auto-address mode is selected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        matched_q <= 1'b0;
    else if (mode_i != MODE_AUTO_ADDR)  matched_q <= 1'b0;
    else if (valid_i && is_addr)        matched_q <= hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      data_o <= '0;
    end else begin
      we_o <= valid_i & accept;
      if (valid_i) data_o <= payload;
    end
  end

  p_idle_no_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !we_o);
  p_conflict_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == MODE_CONFLICT) |=> !we_o);
  p_aad_addr_dropped_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_addr && mode_i == MODE_AUTO_ADDR) |=> !we_o);
  p_md_addr_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_addr && mode_i == MODE_MULTIDROP) |=> we_o);
  p_md_off_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_addr && rx_off_i && mode_i == MODE_MULTIDROP) |=> !we_o);
endmodule

// File: rtl/rs485_addr_flag.sv
module rs485_addr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic is_addr_i,
  input  logic det_en_i,
  input  logic clr_i,
  output logic flag_o
);
  logic set;
  assign set = valid_i & is_addr_i & det_en_i;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= set | (flag_o & ~clr_i);
  end

  p_flag_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set |=> flag_o);
  p_flag_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set) |=> !flag_o);
  p_flag_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_i,
  input  logic tx_busy_i,
  input  logic req_i,
  input  logic low_act_i,
  output logic rts_o
);
  logic active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= auto_i ? tx_busy_i : req_i;
  end

  assign rts_o = active_q ^ low_act_i;

  p_auto_follows_tx_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_i |=> (active_q == $past(tx_busy_i)));
  p_manual_follows_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_i |=> (active_q == $past(req_i)));
endmodule

// File: rtl/rs485_rx_gate.sv
module rs485_rx_gate
  import rs485_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_valid_i,
  input  logic [DATA_W:0]   char_data_i,
  input  logic              multidrop_en_i,
  input  logic              auto_addr_en_i,
  input  logic              auto_dir_en_i,
  input  logic              addr_det_en_i,
  input  logic [DATA_W-1:0] match_addr_i,
  input  logic              rx_off_i,
  input  logic              tx_busy_i,
  input  logic              rts_req_i,
  input  logic              rts_low_act_i,
  input  logic              addr_clr_i,
  output logic              fifo_we_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              addr_det_o,
  output logic              rts_o
);
  localparam int MARK_BIT = DATA_W;

  rx_mode_e mode;
  assign mode = decode_mode(multidrop_en_i, auto_addr_en_i);

  rs485_addr_filter #(.DATA_W(DATA_W)) i_filter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (char_valid_i),
    .char_i   (char_data_i),
    .mode_i   (mode),
    .match_i  (match_addr_i),
    .rx_off_i (rx_off_i),
    .we_o     (fifo_we_o),
    .data_o   (fifo_data_o)
  );

  rs485_addr_flag i_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (char_valid_i),
    .is_addr_i (char_data_i[MARK_BIT]),
    .det_en_i  (addr_det_en_i),
    .clr_i     (addr_clr_i),
    .flag_o    (addr_det_o)
  );

  rs485_dir_ctrl i_dir (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .auto_i    (auto_dir_en_i),
    .tx_busy_i (tx_busy_i),
    .req_i     (rts_req_i),
    .low_act_i (rts_low_act_i),
    .rts_o     (rts_o)
  );

  p_pass_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && !multidrop_en_i && !auto_addr_en_i)
      |=> (fifo_we_o && fifo_data_o == $past(char_data_i[DATA_W-1:0])));
  p_auto_dir_pin_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_dir_en_i && tx_busy_i) |=> (rts_o != rts_low_act_i));
endmodule

// File: tb/test_rs485_rx_gate.sv
`timescale 1ns/1ps
module test_rs485_rx_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [8:0] chr = '0;
  logic       md = 1'b0, aad = 1'b0, adir = 1'b0, det_en = 1'b0;
  logic [7:0] match = '0;
  logic       rx_off = 1'b0, tx_busy = 1'b0, req = 1'b0, low_act = 1'b1, clr = 1'b0;
  logic       we, det, rts;
  logic [7:0] wdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rs485_rx_gate i_rs485_rx_gate (
    .clk_i(clk), .rst_ni(rst_n), .char_valid_i(valid), .char_data_i(chr),
    .multidrop_en_i(md), .auto_addr_en_i(aad), .auto_dir_en_i(adir),
    .addr_det_en_i(det_en), .match_addr_i(match), .rx_off_i(rx_off),
    .tx_busy_i(tx_busy), .rts_req_i(req), .rts_low_act_i(low_act),
    .addr_clr_i(clr), .fifo_we_o(we), .fifo_data_o(wdata),
    .addr_det_o(det), .rts_o(rts)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive a character for one cycle, sample half a cycle after the edge
  task automatic send(logic [8:0] c, logic exp_we, string req);
    @(negedge clk);
    valid = 1'b1; chr = c;
    @(negedge clk);
    valid = 1'b0;
    chk(req, {31'd0, we}, {31'd0, exp_we});
    if (exp_we) chk(req, {24'd0, wdata}, {24'd0, c[7:0]});
  endtask

  task automatic t_reset;
    chk("R1", {31'd0, we}, 0);
    chk("R2", {31'd0, det}, 0);
    chk("R10", {31'd0, rts}, 1);
  endtask

  task automatic t_pass;
    send(9'h0A5, 1'b1, "R1");
    send(9'h133, 1'b1, "R1");
    @(negedge clk);
    chk("R1", {31'd0, we}, 0);
  endtask

  task automatic t_flag;
    det_en = 1'b0;
    send(9'h111, 1'b1, "R2");
    chk("R2", {31'd0, det}, 0);
    det_en = 1'b1;
    send(9'h022, 1'b1, "R2");
    chk("R2", {31'd0, det}, 0);
    send(9'h144, 1'b1, "R2");
    chk("R2", {31'd0, det}, 1);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R3", {31'd0, det}, 0);
    @(negedge clk); clr = 1'b1; valid = 1'b1; chr = 9'h155;
    @(negedge clk); clr = 1'b0; valid = 1'b0;
    chk("R3", {31'd0, det}, 1);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    det_en = 1'b0;
  endtask

  task automatic t_auto;
    aad = 1'b1; match = 8'h42;
    send(9'h011, 1'b0, "R4");
    send(9'h155, 1'b0, "R4");
    send(9'h012, 1'b0, "R4");
    send(9'h142, 1'b0, "R4");
    send(9'h022, 1'b1, "R5");
    send(9'h023, 1'b1, "R5");
    send(9'h142, 1'b0, "R4");
    send(9'h024, 1'b1, "R5");
    send(9'h160, 1'b0, "R4");
    send(9'h025, 1'b0, "R5");
    send(9'h142, 1'b0, "R4");
    @(negedge clk); aad = 1'b0;
    @(negedge clk); aad = 1'b1;
    send(9'h026, 1'b0, "R5");
    aad = 1'b0;
  endtask

  task automatic t_multidrop;
    md = 1'b1; rx_off = 1'b1;
    send(9'h031, 1'b0, "R8");
    send(9'h1AB, 1'b1, "R7");
    rx_off = 1'b0;
    send(9'h032, 1'b1, "R8");
    send(9'h1CD, 1'b1, "R7");
    aad = 1'b1;
    send(9'h033, 1'b0, "R6");
    send(9'h1CD, 1'b0, "R6");
    aad = 1'b0; md = 1'b0;
  endtask

  task automatic t_dir;
    @(negedge clk); adir = 1'b1; req = 1'b1; tx_busy = 1'b0; low_act = 1'b1;
    @(negedge clk);
    chk("R9", {31'd0, rts}, 1);
    tx_busy = 1'b1;
    @(negedge clk);
    chk("R9", {31'd0, rts}, 0);
    tx_busy = 1'b0;
    @(negedge clk);
    chk("R9", {31'd0, rts}, 1);
    adir = 1'b0;
    @(negedge clk);
    chk("R10", {31'd0, rts}, 0);
    low_act = 1'b0; #1;
    chk("R11", {31'd0, rts}, 1);
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    chk("R10", {31'd0, rts}, 0);
    low_act = 1'b1; #1;
    chk("R11", {31'd0, rts}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_pass();
    t_flag();
    t_auto();
    t_multidrop();
    t_dir();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule